// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is the arithmetic and logic unit of a simple processor datapath. It takes two operands and a three-bit function code and returns a result word plus a flag that is high when that result is all zeros. The five functions are bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. A compare-for-equality branch uses the zero flag after a subtraction.

One control bit, `sub_i`, inverts the second operand and supplies the adder carry-in, so the same adder handles both addition and subtraction. A two-bit select, `op_i`, chooses among the logic outputs, the adder sum and a one-bit "less" value. The "less" value is the sign of the difference corrected by signed overflow. The block has no clock and holds no state.

Top module: `alu5_core`

## Requirements
- R1: Code {sub_i, op_i} = 3'b000 gives result_o = opa_i & opb_i.
- R2: Code 3'b001 gives result_o = opa_i | opb_i.
- R3: Code 3'b010 gives result_o = (opa_i + opb_i) modulo 2^WIDTH.
- R4: Code 3'b110 gives result_o = (opa_i - opb_i) modulo 2^WIDTH.
- R5: Code 3'b111 gives result_o bit 0 = 1 when opa_i is less than opb_i as two's-complement signed values, and 0 otherwise. Bits WIDTH-1 to 1 are 0. The answer is correct even when the difference overflows.
- R6: zero_o is 1 exactly when result_o is all zeros, for every code.
- R7: The unused codes 3'b011, 3'b100 and 3'b101 give result_o = opa_i & opb_i, so the output is always defined.
- R8: The outputs follow a change of the inputs with no clock edge in between. The block has no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| sub_i | input | 1 | Inverts opb_i and sets the adder carry-in |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | WIDTH | Function result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The zero flag is produced in the same evaluation as every function. Where it matters most is subtraction of equal operands and set-less-than on operands that are not less, because there it must rise together with the arithmetic result. These pairs are provoked in two ways: directed cases with equal operands, and opposite-sign extremes where the subtraction overflows and the raw sign bit gives the wrong answer. Random operand pairs are added under every code, including the unused codes. A bench model computes the expected result and the expected zero flag separately, and the bench compares both.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
    typedef enum logic [2:0] {
        FN_AND  = 3'b000,
        FN_OR   = 3'b001,
        FN_ADD  = 3'b010,
        FN_SUB  = 3'b110,
        FN_LESS = 3'b111
    } alu_fn_e;

    localparam logic [1:0] SEL_AND  = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_SUM  = 2'b10;
    localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/alu5_adder.sv
module alu5_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             less_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_mod_d;
    logic [WIDTH:0]   sum_ext_d;
    logic             ovf_d;

    always_comb begin
        b_mod_d   = b_i ^ {WIDTH{sub_i}};
        sum_ext_d = {1'b0, a_i} + {1'b0, b_mod_d} + {{WIDTH{1'b0}}, sub_i};
        sum_o     = sum_ext_d[WIDTH-1:0];
        ovf_d     = (a_i[MSB] == b_mod_d[MSB]) && (sum_o[MSB] != a_i[MSB]);
        less_o    = sum_o[MSB] ^ ovf_d;
    end

    // Arithmetic identities checked against the operands
    always_comb begin
        if (!sub_i) begin
            assert_sum_inverse_R3: assert (sum_o - b_i == a_i)
                else $error("adder sum does not invert back to operand a");
        end else begin
            assert_diff_inverse_R4: assert (sum_o + b_i == a_i)
                else $error("adder difference does not invert back to operand a");
            assert_less_sign_R5: assert (less_o == ($signed(a_i) < $signed(b_i)))
                else $error("less flag disagrees with signed compare");
        end
    end
endmodule

// File: rtl/alu5_logic.sv
module alu5_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
    end

    always_comb begin
        assert_and_subset_R1: assert ((and_o & ~a_i) == '0 && (and_o & ~b_i) == '0)
            else $error("AND output sets a bit absent from an operand");
        assert_or_superset_R2: assert ((a_i & ~or_o) == '0 && (b_i & ~or_o) == '0)
            else $error("OR output drops an operand bit");
    end
endmodule

// File: rtl/alu5_select.sv
module alu5_select
    import alu5_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       fn_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             less_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    logic       legal_d;
    logic [1:0] sel_d;

    always_comb begin
        legal_d = (fn_i == FN_AND) || (fn_i == FN_OR) || (fn_i == FN_ADD) ||
                  (fn_i == FN_SUB) || (fn_i == FN_LESS);
        sel_d   = legal_d ? fn_i[1:0] : SEL_AND;
        unique case (sel_d)
            SEL_AND:  result_o = and_i;
            SEL_OR:   result_o = or_i;
            SEL_SUM:  result_o = sum_i;
            SEL_LESS: result_o = {{(WIDTH-1){1'b0}}, less_i};
            default:  result_o = and_i;
        endcase
        zero_o = ~|result_o;
    end

    always_comb begin
        if (sel_d == SEL_LESS) begin
            assert_less_upper_R5: assert (result_o[WIDTH-1:1] == '0)
                else $error("less result has upper bits set");
        end
        if (!legal_d) begin
            assert_unused_and_R7: assert (result_o == and_i)
                else $error("unused code did not yield AND result");
        end
    end
endmodule

// File: rtl/alu5_core.sv
module alu5_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    logic [WIDTH-1:0] and_w, or_w, sum_w;
    logic             less_w;

    alu5_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i(opa_i), .b_i(opb_i), .and_o(and_w), .or_o(or_w)
    );

    alu5_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i(opa_i), .b_i(opb_i), .sub_i(sub_i), .sum_o(sum_w), .less_o(less_w)
    );

    alu5_select #(.WIDTH(WIDTH)) u_select (
        .fn_i({sub_i, op_i}), .and_i(and_w), .or_i(or_w), .sum_i(sum_w),
        .less_i(less_w), .result_o(result_o), .zero_o(zero_o)
    );

    always_comb begin
        if ({sub_i, op_i} == 3'b110) begin
            assert_equal_zero_R6: assert ((opa_i == opb_i) == zero_o)
                else $error("zero flag disagrees with operand equality after subtract");
        end
    end
endmodule

// File: tb/alu5_core_bench.sv
module alu5_core_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic         sub;
    logic [1:0]   op;
    logic [W-1:0] res;
    logic         zf;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    alu5_core #(.WIDTH(W)) u_alu5_core (
        .opa_i(a), .opb_i(b), .sub_i(sub), .op_i(op), .result_o(res), .zero_o(zf)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2:0] c);
        case (c)
            3'b000:  return x & y;
            3'b001:  return x | y;
            3'b010:  return x + y;
            3'b110:  return x - y;
            3'b111:  return ($signed(x) < $signed(y)) ? 1 : 0;
            default: return x & y;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
        logic [W-1:0] e;
        @(posedge clk);
        a = x; b = y; {sub, op} = c;
        @(negedge clk);
        e = model(x, y, c);
        check(tag(c), res, e);
        check("R6", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, (e == '0)});
    endtask

    initial begin
        logic [2:0] codes [8];
        codes = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
        a = '0; b = '0; sub = 0; op = 0;
        void'($urandom(32'h5EED_0A1C));
        @(negedge clk);
        check("R6", {{(W-1){1'b0}}, zf}, 1);
        // directed corners
        run(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000);   // R1 disjoint -> zero
        run(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b001);   // R2
        run(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);   // R3 wrap to zero
        run(32'h1234_5678, 32'h1234_5678, 3'b110);   // R4 equal -> zero
        run(32'h0000_0000, 32'h0000_0001, 3'b110);   // R4 borrow
        run(32'h8000_0000, 32'h0000_0001, 3'b111);   // R5 overflow, less
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);   // R5 overflow, not less
        run(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);   // R5 -1 < 0
        run(32'h0000_0005, 32'h0000_0005, 3'b111);   // R5 equal -> zero
        run(32'hAAAA_AAAA, 32'h5555_5555, 3'b011);   // R7
        run(32'hFFFF_0000, 32'hFF00_FF00, 3'b100);   // R7
        run(32'h0000_0000, 32'hFFFF_FFFF, 3'b101);   // R7
        // R8: inputs change between edges, outputs follow without a clock
        @(posedge clk);
        #3 a = 32'd9; b = 32'd4; {sub, op} = 3'b110;
        #1 check("R8", res, 32'd5);
        #1 b = 32'd9;
        #1 check("R8", res, 32'd0);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] x, y;
            logic [2:0] c;
            x = $urandom();
            y = (i % 7 == 0) ? x : $urandom();
            if (i % 11 == 0) y = {~x[W-1], y[W-2:0]};
            c = codes[i % 8];
            run(x, y, c);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule